// File: doc/BRIEF.md
# Electronic Cam Event Controller

This block follows a shaft or axis position held as a modulo count. Single-cycle up and down count pulses move the position one step at a time. The position runs from zero to a programmable maximum and wraps back to zero. A 32-bit revolution register counts the forward wraps.

A table of up to 200 cam entries is written through a word-addressed port while the block is disabled. Each entry names a target position and an action. The action sets or clears one bit in either an internal flag bank or an external output port. When enable rises, the block walks the table looking for the all-ones terminator. It enters its run state only if it finds one.

In the run state, every forward step starts a scan engine. The engine compares one entry per clock against the new position and applies each matching action right away. The port bits therefore change within the scan, not at some later periodic update.

Top module: `cam_event_ctrl`

## Requirements
- R1: While running, an accepted up pulse raises `position` by one. When `position` equals `max_pos`, an up pulse returns it to 0 instead.
- R2: `revolutions` rises by exactly one on each forward wrap from `max_pos` to 0 and changes on no other step while running. Both `position` and `revolutions` read 0 whenever the block is not running.
- R3: An accepted down pulse lowers `position` by one, or moves it from 0 to `max_pos`. It never changes `revolutions` and never triggers any table action, even when it lands on a target.
- R4: When a forward step lands `position` on an entry's target, that entry's action is applied. Kind 1 drives `out_port[index]` and kind 0 drives `flag_bank[index]`. Action 1 sets the bit and action 0 clears it. Bits with no matching entry keep their values, and all bits reset to 0.
- R5: A target greater than `max_pos` behaves as `max_pos`. A target of 0 fires on the forward wrap into 0.
- R6: Entries may appear in any order, and several entries may share one target. All matching entries fire during the same scan, applied in table order.
- R7: Table format and loading. The slot is `wr_addr[8:1]`. When `wr_addr[0]`=0 the word is the 32-bit target. When `wr_addr[0]`=1 the word is the control word, with bit 0 the action, bit 1 the kind and bits 15:8 the index. Writes take effect only while `enable` is low and are ignored while it is high.
- R8: After `enable` rises, the block searches slots 0 to 200 for a target word of all ones. If it finds one, `running` goes high and the entries before that slot form the table. Otherwise `table_err` goes high and `running` stays low. Both flags return to 0 when `enable` falls.
- R9: `busy` is high during the one-cycle-per-entry scan that follows each forward step. An up or down pulse seen while `busy` is high is dropped, and it sets the sticky `overrun` flag, which clears only when `enable` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | High to verify the table and run; low to stop and allow loading |
| wr_en | input | 1 | Table word write strobe |
| wr_addr | input | 9 | Table word address: slot in bits 8:1, word select in bit 0 |
| wr_data | input | 32 | Table word data |
| max_pos | input | 32 | Highest position value; hold stable while enabled |
| cnt_up | input | 1 | Forward count pulse |
| cnt_dn | input | 1 | Reverse count pulse |
| position | output | 32 | Current modulo position |
| revolutions | output | 32 | Forward wrap count |
| flag_bank | output | 16 | Internal flag bits driven by kind-0 entries |
| out_port | output | 16 | External output bits driven by kind-1 entries |
| running | output | 1 | Table verified, counting active |
| busy | output | 1 | Scan in progress |
| table_err | output | 1 | No terminator found in slots 0 to 200 |
| overrun | output | 1 | A count pulse arrived during a scan |

## Verification
The hardest case to reach is a down step that lands on a target whose bit is still clear. Only that case shows that reverse motion has no effect. The stimulus first runs the position forward through a full turn, so the wrap clears the target-3 output. It then steps down seven times from 0 onto that target and checks that the bit stays clear. A later forward pass over the same target then sets it. Between those two passes, a write aimed at the running table places a terminator over entry 0. The set that follows shows the write was ignored. The terminator-at-slot-200 boundary is reached by loading a full 200-entry table, whose scans each last 200 cycles.

// File: rtl/cam_evt_pkg.sv
// Shared types for the electronic cam event controller.
// Assumes: control word layout is action in bit 0, kind in bit 1, index in bits 15:8.
package cam_evt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RUN   = 2'd2,
        ST_FAULT = 2'd3
    } cam_state_t;

    typedef struct packed {
        logic [7:0] index;
        logic       kind;
        logic       act;
    } cam_ctrl_t;

endpackage

// File: rtl/cam_table.sv
// Cam entry storage: one target word and one control word per slot.
// Assumes: wr_ok is already qualified by the sequencer (loading allowed only when idle).
module cam_table
    import cam_evt_pkg::*;
#(
    parameter int POS_W  = 32,
    parameter int SLOTS  = 201,
    parameter int ADDR_W = 9,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [POS_W-1:0]  rd_target,
    output cam_ctrl_t         rd_ctrl
);

    localparam int SLOT_W = ADDR_W - 1;

    logic [POS_W-1:0] tgt_mem [SLOTS];
    cam_ctrl_t        ctl_mem [SLOTS];
    logic [SLOT_W-1:0] wr_slot;
    logic              unused_wr_bits;

    assign wr_slot        = wr_addr[ADDR_W-1:1];
    assign unused_wr_bits = ^{wr_data[31:16], wr_data[7:2]};

    // Store a target or control word into the addressed slot.
    always_ff @(posedge clk) begin
        if (wr_ok && (32'(wr_slot) < SLOTS)) begin
            if (!wr_addr[0]) begin
                tgt_mem[wr_slot] <= wr_data[POS_W-1:0];
            end else begin
                ctl_mem[wr_slot] <= '{index: wr_data[15:8], kind: wr_data[1], act: wr_data[0]};
            end
        end
    end

    // Combinational read of the slot selected by the sequencer.
    always_comb begin
        if (32'(rd_idx) < SLOTS) begin
            rd_target = tgt_mem[rd_idx];
            rd_ctrl   = ctl_mem[rd_idx];
        end else begin
            rd_target = '0;
            rd_ctrl   = '0;
        end
    end

endmodule

// File: rtl/cam_pos_counter.sv
// Modulo position counter with forward revolution tally.
// Assumes: step_up and step_dn are never high together; max_pos stable while counting.
module cam_pos_counter #(
    parameter int POS_W = 32,
    parameter int REV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic [POS_W-1:0] max_pos,
    output logic [POS_W-1:0] position,
    output logic [REV_W-1:0] revolutions
);

    // Advance, retreat or clear the position and revolution count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            position    <= '0;
            revolutions <= '0;
        end else if (step_up) begin
            if (position >= max_pos) begin
                position    <= '0;
                revolutions <= revolutions + 1'b1;
            end else begin
                position <= position + 1'b1;
            end
        end else if (step_dn) begin
            if (position == '0) begin
                position <= max_pos;
            end else begin
                position <= position - 1'b1;
            end
        end
    end

endmodule

// File: rtl/cam_action_unit.sv
// Applies a matched cam action to one bit of the flag bank or the output port.
// Assumes: at most one apply per cycle; out-of-range indexes are dropped.
module cam_action_unit
    import cam_evt_pkg::*;
#(
    parameter int FLAG_W = 16,
    parameter int OUT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  cam_ctrl_t         ctrl,
    output logic [FLAG_W-1:0] flag_bank,
    output logic [OUT_W-1:0]  out_port
);

    for (genvar b = 0; b < FLAG_W; b++) begin : g_flag
        // Update one internal flag bit when a kind-0 entry addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_bank[b] <= 1'b0;
            end else if (apply && !ctrl.kind && (32'(ctrl.index) == b)) begin
                flag_bank[b] <= ctrl.act;
            end
        end
    end

    for (genvar b = 0; b < OUT_W; b++) begin : g_out
        // Update one output port bit when a kind-1 entry addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_port[b] <= 1'b0;
            end else if (apply && ctrl.kind && (32'(ctrl.index) == b)) begin
                out_port[b] <= ctrl.act;
            end
        end
    end

endmodule

// File: rtl/cam_sequencer.sv
// Control: table verification after enable, pulse acceptance, and the per-step scan.
// Assumes: table contents are stable while enable is high (writes are blocked here).
module cam_sequencer
    import cam_evt_pkg::*;
#(
    parameter int POS_W = 32,
    parameter int SLOTS = 201,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cnt_up,
    input  logic             cnt_dn,
    input  logic [POS_W-1:0] position,
    input  logic [POS_W-1:0] max_pos,
    input  logic [POS_W-1:0] rd_target,
    output logic [IDX_W-1:0] rd_idx,
    output logic             step_up,
    output logic             step_dn,
    output logic             clear_cnt,
    output logic             wr_allow,
    output logic             apply,
    output logic             running,
    output logic             busy,
    output logic             table_err,
    output logic             overrun
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS - 1);

    cam_state_t       state;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] n_entries;
    logic             accept;
    logic [POS_W-1:0] eff_target;

    assign running   = (state == ST_RUN);
    assign accept    = running && !busy && (cnt_up ^ cnt_dn);
    assign step_up   = accept && cnt_up;
    assign step_dn   = accept && cnt_dn;
    assign clear_cnt = !running;
    assign wr_allow  = !enable && (state == ST_IDLE);
    assign rd_idx    = idx;

    // Clamp the entry target to the maximum position.
    always_comb begin
        eff_target = (rd_target > max_pos) ? max_pos : rd_target;
    end

    assign apply = running && busy && (eff_target == position);

    // Verify the table, then run the scan once per forward step.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state     <= ST_IDLE;
            idx       <= '0;
            n_entries <= '0;
            busy      <= 1'b0;
            table_err <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    state <= ST_CHECK;
                    idx   <= '0;
                end
                ST_CHECK: begin
                    if (rd_target == '1) begin
                        n_entries <= idx;
                        idx       <= '0;
                        state     <= ST_RUN;
                    end else if (idx == LAST_SLOT) begin
                        table_err <= 1'b1;
                        state     <= ST_FAULT;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (busy) begin
                        if (cnt_up || cnt_dn) begin
                            overrun <= 1'b1;
                        end
                        if (idx == n_entries - 1'b1) begin
                            busy <= 1'b0;
                            idx  <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else if (step_up && (n_entries != '0)) begin
                        busy <= 1'b1;
                        idx  <= '0;
                    end
                end
                default: state <= ST_FAULT;
            endcase
        end
    end

endmodule

// File: rtl/cam_event_ctrl.sv
// Top of the electronic cam event controller: ties table, counter, sequencer and actions.
// Assumes: count pulses are single-cycle and spaced beyond the scan length.
module cam_event_ctrl
    import cam_evt_pkg::*;
#(
    parameter int POS_W       = 32,
    parameter int REV_W       = 32,
    parameter int MAX_ENTRIES = 200,
    parameter int FLAG_W      = 16,
    parameter int OUT_W       = 16,
    parameter int ADDR_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [POS_W-1:0]  max_pos,
    input  logic              cnt_up,
    input  logic              cnt_dn,
    output logic [POS_W-1:0]  position,
    output logic [REV_W-1:0]  revolutions,
    output logic [FLAG_W-1:0] flag_bank,
    output logic [OUT_W-1:0]  out_port,
    output logic              running,
    output logic              busy,
    output logic              table_err,
    output logic              overrun
);

    localparam int SLOTS = MAX_ENTRIES + 1;
    localparam int IDX_W = $clog2(SLOTS + 1);

    logic [IDX_W-1:0] rd_idx;
    logic [POS_W-1:0] rd_target;
    cam_ctrl_t        rd_ctrl;
    logic             step_up;
    logic             step_dn;
    logic             clear_cnt;
    logic             wr_allow;
    logic             apply;

    cam_table #(
        .POS_W (POS_W),
        .SLOTS (SLOTS),
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) u_table (
        .clk      (clk),
        .wr_ok    (wr_en && wr_allow),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_target(rd_target),
        .rd_ctrl  (rd_ctrl)
    );

    cam_pos_counter #(
        .POS_W(POS_W),
        .REV_W(REV_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_cnt),
        .step_up    (step_up),
        .step_dn    (step_dn),
        .max_pos    (max_pos),
        .position   (position),
        .revolutions(revolutions)
    );

    cam_sequencer #(
        .POS_W(POS_W),
        .SLOTS(SLOTS),
        .IDX_W(IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .cnt_up   (cnt_up),
        .cnt_dn   (cnt_dn),
        .position (position),
        .max_pos  (max_pos),
        .rd_target(rd_target),
        .rd_idx   (rd_idx),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .clear_cnt(clear_cnt),
        .wr_allow (wr_allow),
        .apply    (apply),
        .running  (running),
        .busy     (busy),
        .table_err(table_err),
        .overrun  (overrun)
    );

    cam_action_unit #(
        .FLAG_W(FLAG_W),
        .OUT_W (OUT_W)
    ) u_action (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply    (apply),
        .ctrl     (rd_ctrl),
        .flag_bank(flag_bank),
        .out_port (out_port)
    );

endmodule

// File: rtl/cam_event_ctrl_chk.sv
// Property checker for cam_event_ctrl, attached through bind.
module cam_event_ctrl_chk #(
    parameter int POS_W  = 32,
    parameter int REV_W  = 32,
    parameter int FLAG_W = 16,
    parameter int OUT_W  = 16,
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [POS_W-1:0]  max_pos,
    input logic              cnt_up,
    input logic              cnt_dn,
    input logic [POS_W-1:0]  position,
    input logic [REV_W-1:0]  revolutions,
    input logic [FLAG_W-1:0] flag_bank,
    input logic [OUT_W-1:0]  out_port,
    input logic              running,
    input logic              busy,
    input logic              table_err,
    input logic              overrun
);

    // R1
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> position <= max_pos);

    // R2
    rev_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !$stable(revolutions)) |-> ($past(position) == $past(max_pos) && position == '0));

    // R3
    down_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_dn) && !$past(cnt_up) && $past(running) && !$past(busy) && running) |-> $stable(revolutions));

    // R4
    out_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_port) |-> $past(busy));

    // R8
    err_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(table_err && running));

    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && running && busy && cnt_up) |=> overrun);

    // R9
    busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> running);

endmodule

bind cam_event_ctrl cam_event_ctrl_chk #(
    .POS_W (POS_W),
    .REV_W (REV_W),
    .FLAG_W(FLAG_W),
    .OUT_W (OUT_W),
    .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/cam_event_ctrl_test.sv
module cam_event_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] max_pos = 32'd9;
    logic        cnt_up = 1'b0;
    logic        cnt_dn = 1'b0;
    logic [31:0] position;
    logic [31:0] revolutions;
    logic [15:0] flag_bank;
    logic [15:0] out_port;
    logic        running;
    logic        busy;
    logic        table_err;
    logic        overrun;

    int total = 0;
    int bad = 0;
    int scan_len = 7;

    always #4 clk = ~clk;

    cam_event_ctrl uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .max_pos(max_pos),
        .cnt_up(cnt_up), .cnt_dn(cnt_dn), .position(position),
        .revolutions(revolutions), .flag_bank(flag_bank), .out_port(out_port),
        .running(running), .busy(busy), .table_err(table_err), .overrun(overrun)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_entry(input int slot, input logic [31:0] tgt, input bit kind,
                               input int idx, input bit act);
        write_word(slot * 2, tgt);
        write_word(slot * 2 + 1, {16'h0, 8'(idx), 6'h0, kind, act});
    endtask

    task automatic step(input bit up, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt_up = up; cnt_dn = !up;
            @(negedge clk);
            cnt_up = 1'b0; cnt_dn = 1'b0;
            cycles(scan_len + 3);
        end
    endtask

    task automatic test_reset();
        chk("R2 reset position", position, 0);
        chk("R2 reset revolutions", revolutions, 0);
        chk("R4 reset out_port", 32'(out_port), 0);
        chk("R4 reset flag_bank", 32'(flag_bank), 0);
        chk("R8 reset running", 32'(running), 0);
    endtask

    task automatic test_load_and_enable();
        write_entry(0, 3, 1, 2, 1);
        write_entry(1, 5, 0, 4, 1);
        write_entry(2, 3, 0, 7, 1);
        write_entry(3, 100, 1, 5, 1);
        write_entry(4, 0, 1, 2, 0);
        write_entry(5, 4, 1, 3, 1);
        write_entry(6, 8, 1, 6, 1);
        write_word(14, 32'hFFFF_FFFF);
        scan_len = 7;
        enable = 1'b1;
        cycles(220);
        chk("R8 running after terminator", 32'(running), 1);
        chk("R8 no table_err", 32'(table_err), 0);
    endtask

    task automatic test_forward();
        step(1'b1, 3);
        chk("R1 position 3", position, 3);
        chk("R4 out bit2 set", 32'(out_port), 32'h04);
        chk("R6 shared target flag bit7", 32'(flag_bank), 32'h80);
        step(1'b1, 1);
        chk("R6 unordered entry at 4", 32'(out_port), 32'h0C);
        step(1'b1, 1);
        chk("R4 flag bit4 set", 32'(flag_bank), 32'h90);
        step(1'b1, 3);
        chk("R4 out bit6 at 8", 32'(out_port), 32'h4C);
        step(1'b1, 1);
        chk("R5 clamped target fires at max", 32'(out_port), 32'h6C);
        chk("R1 position at max", position, 9);
        step(1'b1, 1);
        chk("R1 wrap to 0", position, 0);
        chk("R2 revolutions 1", revolutions, 1);
        chk("R5 zero target clears bit2", 32'(out_port), 32'h68);
    endtask

    task automatic test_reverse();
        step(1'b0, 1);
        chk("R3 down wrap to max", position, 9);
        chk("R3 down wrap keeps revolutions", revolutions, 1);
        step(1'b0, 6);
        chk("R3 position 3 reached downward", position, 3);
        chk("R3 no action on downward landing", 32'(out_port), 32'h68);
    endtask

    task automatic test_write_blocked();
        write_word(0, 32'hFFFF_FFFF);
        step(1'b0, 1);
        step(1'b1, 1);
        chk("R7 entry0 intact after running write", 32'(out_port), 32'h6C);
    endtask

    task automatic test_overrun();
        @(negedge clk);
        cnt_up = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cnt_up = 1'b0;
        cycles(scan_len + 3);
        chk("R9 overrun set", 32'(overrun), 1);
        chk("R9 second pulse dropped", position, 4);
        enable = 1'b0;
        cycles(3);
        chk("R9 overrun cleared by disable", 32'(overrun), 0);
        chk("R2 position cleared when stopped", position, 0);
    endtask

    task automatic test_full_table();
        for (int s = 0; s < 200; s++) begin
            write_entry(s, 50, 0, 15, 1);
        end
        write_word(400, 32'hFFFF_FFFF);
        scan_len = 200;
        enable = 1'b1;
        cycles(220);
        chk("R8 terminator at slot 200 accepted", 32'(running), 1);
        step(1'b1, 9);
        chk("R5 full table clamp fires flag15", 32'(flag_bank), 32'h8090);
        enable = 1'b0;
        cycles(3);
        write_word(400, 32'h0);
        enable = 1'b1;
        cycles(220);
        chk("R8 missing terminator error", 32'(table_err), 1);
        chk("R8 not running on error", 32'(running), 0);
    endtask

    initial begin : watchdog
        #1500000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
        test_reset();
        test_load_and_enable();
        test_forward();
        test_reverse();
        test_write_blocked();
        test_overrun();
        test_full_table();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule